// File: doc/BRIEF.md
# 32-bit Memory EDAC Codec

This block sits between a processor core and a 40-bit memory data path. On the write side it takes a 32-bit word and produces 7 check bits and one odd-parity bit, which travel to memory with the data. On the read side it takes the 40 bits back and recomputes the code. It repairs any single flipped bit and reports a correctable event. A double error, or a bus that reads as a stuck pattern, is reported as non-correctable.

The check bits form an odd-weight-column code. Every data bit owns a distinct weight-3 column, and each check bit owns a weight-1 column. The parity bit covers the data only and acts as a second, independent witness. A fixed inversion mask on two check bits keeps the all-zero and all-one buses, and every single-nibble stuck pattern, away from any syndrome that could be mistaken for a one-bit error. A mode input picks no protection, parity only, or parity plus correction. An I/O qualifier limits the access to the parity choice. Both paths are registered, so each result appears one clock after its strobe.

Top module: `edac_codec`

## Requirements
- R1: In correction mode (mode 2'b10 or 2'b11, io_acc low), one cycle after wr_en the block presents wr_par = odd parity over wr_data. It also presents wr_chk = XOR of column[i] over every set data bit i, XORed with 7'b0000011, where column[i] is the i-th 7-bit value of weight three in ascending numeric order. Both outputs hold their value while wr_en is low.
- R2: With mode 2'b01 the write path gives the odd parity bit and wr_chk = 0. With mode 2'b00 it gives wr_chk = 0 and wr_par = 0.
- R3: In correction mode, reading back a bus that R1 encoded returns the data unchanged, with rd_ce and rd_ue both low.
- R4: In correction mode, a single flipped data bit is restored on rd_data and rd_ce is raised.
- R5: In correction mode, a single flipped check bit or parity bit leaves rd_data equal to the stored data and raises rd_ce.
- R6: In correction mode, any two flipped bits among the 40 bus bits raise rd_ue and keep rd_ce low.
- R7: In correction mode, each of the following raises rd_ue and keeps rd_ce low: a bus of all zeros, a bus of all ones, any one data nibble all ones with every other bus bit zero, and any one data nibble all zeros with every other bus bit one.
- R8: With mode 2'b01, a parity mismatch raises rd_ue, rd_ce stays low, rd_data equals the raw data, and the check-bit inputs have no effect.
- R9: With mode 2'b00, rd_ce and rd_ue stay low and rd_data equals the raw read data, whatever the bus holds.
- R10: With io_acc high, correction is off. A nonzero mode gives parity-only behaviour on both paths (wr_chk = 0, mismatch gives rd_ue, no repair).
- R11: rd_valid, rd_data, rd_ce and rd_ue update one cycle after rd_en. The flags are single-cycle pulses tied to rd_valid, and rd_ce and rd_ue are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 2 | 00 none, 01 parity only, 10/11 parity plus correction |
| io_acc | input | 1 | Access targets I/O: correction disabled |
| wr_en | input | 1 | Encode strobe for wr_data |
| wr_data | input | 32 | Word to be written |
| wr_chk | output | 7 | Check bits for memory |
| wr_par | output | 1 | Odd parity bit for memory |
| rd_en | input | 1 | Decode strobe for the raw read bus |
| rd_raw | input | 32 | Data bits read from memory |
| rd_raw_chk | input | 7 | Check bits read from memory |
| rd_raw_par | input | 1 | Parity bit read from memory |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Corrected read data |
| rd_ce | output | 1 | Correctable error pulse |
| rd_ue | output | 1 | Non-correctable error pulse |

## Verification
Every result is due exactly one rising edge after its strobe. The encoded check and parity bits follow wr_en, and the repaired word and both flags follow rd_en. The bench drives each strobe for one cycle from a falling edge and reads the outputs at the next falling edge, so every sample falls between the edge that loads the result and the following one. After a flagged read it spends one more idle cycle and confirms that the pulse has dropped. The expected code bits, every one of the 40 single flips, every pair of flips and all sixteen nibble stuck patterns are computed in the bench from the column rule.

// File: rtl/edac_pkg.sv
package edac_pkg;

  typedef enum logic [1:0] {
    PROT_NONE = 2'b00,
    PROT_PAR  = 2'b01,
    PROT_FULL = 2'b10,
    PROT_ALT  = 2'b11
  } prot_e;

  // idx-th value of weight three among cw-bit numbers, ascending
  function automatic logic [15:0] hcol(input int idx, input int cw);
    int          seen;
    logic [15:0] r;
    seen = 0;
    r    = '0;
    for (int v = 0; v < (1 << cw); v++) begin
      if ($countones(v) == 3) begin
        if (seen == idx) r = v[15:0];
        seen++;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/edac_enc.sv
module edac_enc #(
  parameter int              DW   = 32,
  parameter int              CW   = 7,
  parameter logic [CW-1:0]   FLIP = CW'(3)
) (
  input  logic [DW-1:0] data,
  output logic [CW-1:0] chk,
  output logic          par
);

  logic [CW-1:0] term [DW];
  logic [CW-1:0] acc;

  for (genvar i = 0; i < DW; i++) begin : g_col
    localparam logic [15:0] COLW = edac_pkg::hcol(i, CW);
    assign term[i] = data[i] ? COLW[CW-1:0] : '0;
  end

  always_comb begin
    acc = FLIP;
    for (int i = 0; i < DW; i++) acc = acc ^ term[i];
  end

  assign chk = acc;
  assign par = ~^data;

endmodule

// File: rtl/edac_dec.sv
module edac_dec #(
  parameter int              DW   = 32,
  parameter int              CW   = 7,
  parameter logic [CW-1:0]   FLIP = CW'(3)
) (
  input  logic [DW-1:0] data,
  input  logic [CW-1:0] chk,
  input  logic          par,
  input  logic          edac_on,
  input  logic          par_on,
  output logic [DW-1:0] fixed,
  output logic          ce,
  output logic          ue
);

  logic [CW-1:0] calc_chk;
  logic          calc_par;
  logic [CW-1:0] syn;
  logic          pe;
  logic [DW-1:0] hit;
  logic          syn_zero;
  logic          syn_one;
  logic          fixable;

  edac_enc #(.DW(DW), .CW(CW), .FLIP(FLIP)) u_recalc (
    .data (data),
    .chk  (calc_chk),
    .par  (calc_par)
  );

  assign syn = calc_chk ^ chk;
  assign pe  = calc_par ^ par;

  for (genvar i = 0; i < DW; i++) begin : g_hit
    localparam logic [15:0] COLW = edac_pkg::hcol(i, CW);
    assign hit[i] = (syn == COLW[CW-1:0]);
  end

  always_comb begin
    syn_zero = (syn == '0);
    syn_one  = !syn_zero && ((syn & (syn - 1'b1)) == '0);
    // parity mismatch: either the parity bit alone or one data bit
    // parity clean: only a lone check bit may be repaired
    fixable  = pe ? (syn_zero || (|hit)) : syn_one;
    if (edac_on) begin
      ce    = fixable;
      ue    = !fixable && (pe || !syn_zero);
      fixed = data ^ (hit & {DW{pe}});
    end else begin
      ce    = 1'b0;
      ue    = par_on && pe;
      fixed = data;
    end
  end

endmodule

// File: rtl/edac_codec.sv
module edac_codec #(
  parameter int                  DATA_W   = 32,
  parameter int                  CHK_W    = 7,
  parameter logic [CHK_W-1:0]    CHK_FLIP = CHK_W'(3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              io_acc,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CHK_W-1:0]  wr_chk,
  output logic              wr_par,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] rd_raw,
  input  logic [CHK_W-1:0]  rd_raw_chk,
  input  logic              rd_raw_par,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ce,
  output logic              rd_ue
);

  import edac_pkg::*;

  logic              rst_meta;
  logic              rst_ok;
  prot_e             prot;
  logic              par_on;
  logic              edac_on;

  logic [CHK_W-1:0]  gen_chk;
  logic              gen_par;
  logic [CHK_W-1:0]  wr_chk_d;
  logic              wr_par_d;

  logic [DATA_W-1:0] dec_fix;
  logic              dec_ce;
  logic              dec_ue;
  logic              rd_valid_d;
  logic [DATA_W-1:0] rd_data_d;
  logic              rd_ce_d;
  logic              rd_ue_d;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ok   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ok   <= rst_meta;
    end
  end

  always_comb begin
    prot    = prot_e'(mode);
    par_on  = (prot != PROT_NONE);
    edac_on = ((prot == PROT_FULL) || (prot == PROT_ALT)) && !io_acc;
  end

  edac_enc #(.DW(DATA_W), .CW(CHK_W), .FLIP(CHK_FLIP)) u_enc (
    .data (wr_data),
    .chk  (gen_chk),
    .par  (gen_par)
  );

  edac_dec #(.DW(DATA_W), .CW(CHK_W), .FLIP(CHK_FLIP)) u_dec (
    .data    (rd_raw),
    .chk     (rd_raw_chk),
    .par     (rd_raw_par),
    .edac_on (edac_on),
    .par_on  (par_on),
    .fixed   (dec_fix),
    .ce      (dec_ce),
    .ue      (dec_ue)
  );

  // next state: write path
  always_comb begin
    wr_chk_d = edac_on ? gen_chk : '0;
    wr_par_d = par_on ? gen_par : 1'b0;
  end

  // next state: read path
  always_comb begin
    rd_valid_d = rd_en;
    rd_data_d  = rd_en ? dec_fix : rd_data;
    rd_ce_d    = rd_en && dec_ce;
    rd_ue_d    = rd_en && dec_ue;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      wr_chk <= '0;
      wr_par <= 1'b0;
    end else if (wr_en) begin
      wr_chk <= wr_chk_d;
      wr_par <= wr_par_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_ce    <= 1'b0;
      rd_ue    <= 1'b0;
    end else begin
      rd_valid <= rd_valid_d;
      rd_data  <= rd_data_d;
      rd_ce    <= rd_ce_d;
      rd_ue    <= rd_ue_d;
    end
  end

endmodule

// File: rtl/edac_codec_chk.sv
module edac_codec_chk #(
  parameter int DATA_W = 32,
  parameter int CHK_W  = 7
) (
  input logic              clk,
  input logic              rst_ok,
  input logic [1:0]        mode,
  input logic              io_acc,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_raw,
  input logic [CHK_W-1:0]  wr_chk,
  input logic              wr_par,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_ce,
  input logic              rd_ue
);

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_ok)
    !(rd_ce && rd_ue)); // R11

  AST_VALID_TRACK: assert property (@(posedge clk) disable iff (!rst_ok)
    rd_en |=> rd_valid); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_ok)
    !rd_en |=> (!rd_valid && !rd_ce && !rd_ue)); // R11

  AST_NONE_PASS: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_en && mode == 2'b00) |=> (!rd_ce && !rd_ue && rd_data == $past(rd_raw))); // R9

  AST_PAR_NO_FIX: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_en && mode == 2'b01) |=> (!rd_ce && rd_data == $past(rd_raw))); // R8

  AST_IO_NO_FIX: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_en && io_acc) |=> (!rd_ce && rd_data == $past(rd_raw))); // R10

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    !wr_en |=> ($stable(wr_chk) && $stable(wr_par))); // R1

  AST_WR_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && mode == 2'b00) |=> (wr_chk == '0 && !wr_par)); // R2

  AST_WR_IO_NO_CHK: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && io_acc) |=> (wr_chk == '0)); // R10

endmodule

bind edac_codec edac_codec_chk #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_chk (
  .clk      (clk),
  .rst_ok   (rst_ok),
  .mode     (mode),
  .io_acc   (io_acc),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .rd_raw   (rd_raw),
  .wr_chk   (wr_chk),
  .wr_par   (wr_par),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .rd_ce    (rd_ce),
  .rd_ue    (rd_ue)
);

// File: tb/sim_edac_codec.sv
`timescale 1ns/1ps
module sim_edac_codec;

  logic        clk;
  logic        rst_n;
  logic [1:0]  mode;
  logic        io_acc;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [6:0]  wr_chk;
  logic        wr_par;
  logic        rd_en;
  logic [31:0] rd_raw;
  logic [6:0]  rd_raw_chk;
  logic        rd_raw_par;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        rd_ce;
  logic        rd_ue;

  int n_chk;
  int n_err;
  logic [6:0] colt [32];

  edac_codec u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .io_acc(io_acc),
    .wr_en(wr_en), .wr_data(wr_data), .wr_chk(wr_chk), .wr_par(wr_par),
    .rd_en(rd_en), .rd_raw(rd_raw), .rd_raw_chk(rd_raw_chk), .rd_raw_par(rd_raw_par),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ce(rd_ce), .rd_ue(rd_ue)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [6:0] exp_chk(input logic [31:0] d);
    logic [6:0] c;
    c = 7'b0000011;
    for (int i = 0; i < 32; i++) if (d[i]) c = c ^ colt[i];
    return c;
  endfunction

  function automatic logic odd_par(input logic [31:0] d);
    int ones;
    ones = 0;
    for (int i = 0; i < 32; i++) if (d[i]) ones++;
    return (ones % 2 == 0);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_wr(input logic [31:0] d);
    @(negedge clk);
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic do_rd(input logic [31:0] d, input logic [6:0] c, input logic p);
    @(negedge clk);
    rd_raw     = d;
    rd_raw_chk = c;
    rd_raw_par = p;
    rd_en      = 1'b1;
    @(negedge clk);
    rd_en      = 1'b0;
  endtask

  task automatic rd_expect(input string req, input logic [39:0] bus,
                           input logic chk_data, input logic [31:0] exp_d,
                           input logic exp_ce, input logic exp_ue);
    do_rd(bus[31:0], bus[38:32], bus[39]);
    check(req, "valid", 64'(rd_valid), 64'(1'b1));
    if (chk_data) check(req, "data", 64'(rd_data), 64'(exp_d));
    check(req, "ce", 64'(rd_ce), 64'(exp_ce));
    check(req, "ue", 64'(rd_ue), 64'(exp_ue));
  endtask

  function automatic logic [39:0] enc_bus(input logic [31:0] d);
    return {odd_par(d), exp_chk(d), d};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] words [5];
    int k;
    n_chk = 0;
    n_err = 0;
    k = 0;
    for (int v = 0; v < 128; v++) begin
      int w;
      w = 0;
      for (int b = 0; b < 7; b++) if (v[b]) w++;
      if (w == 3 && k < 32) begin
        colt[k] = v[6:0];
        k++;
      end
    end
    words[0] = 32'h0000_0000;
    words[1] = 32'hFFFF_FFFF;
    words[2] = 32'h1234_5678;
    words[3] = 32'hA5A5_5A5A;
    words[4] = 32'h8000_0001;

    rst_n = 1'b0; mode = 2'b10; io_acc = 1'b0;
    wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
    rd_raw = '0; rd_raw_chk = '0; rd_raw_par = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state (R11, R1)
    check("R11", "reset valid", 64'(rd_valid), 64'(0));
    check("R11", "reset flags", 64'({rd_ce, rd_ue}), 64'(0));
    check("R1", "reset chk/par", 64'({wr_chk, wr_par}), 64'(0));

    // R1: encode in correction mode, both encodings of the mode
    for (int m = 2; m < 4; m++) begin
      mode = 2'(m);
      for (int i = 0; i < 5; i++) begin
        do_wr(words[i]);
        check("R1", "wr_chk", 64'(wr_chk), 64'(exp_chk(words[i])));
        check("R1", "wr_par", 64'(wr_par), 64'(odd_par(words[i])));
      end
    end
    // R1: hold while wr_en low
    @(negedge clk);
    wr_data = 32'hDEAD_BEEF;
    repeat (2) @(negedge clk);
    check("R1", "hold chk", 64'(wr_chk), 64'(exp_chk(words[4])));
    check("R1", "hold par", 64'(wr_par), 64'(odd_par(words[4])));

    // R2: parity only and none
    mode = 2'b01;
    for (int i = 0; i < 5; i++) begin
      do_wr(words[i]);
      check("R2", "par-mode chk", 64'(wr_chk), 64'(0));
      check("R2", "par-mode par", 64'(wr_par), 64'(odd_par(words[i])));
    end
    mode = 2'b00;
    do_wr(words[2]);
    check("R2", "none chk/par", 64'({wr_chk, wr_par}), 64'(0));

    // R10: io write in correction mode
    mode = 2'b10; io_acc = 1'b1;
    do_wr(words[3]);
    check("R10", "io chk", 64'(wr_chk), 64'(0));
    check("R10", "io par", 64'(wr_par), 64'(odd_par(words[3])));
    io_acc = 1'b0;

    // R3: clean reads
    for (int i = 0; i < 5; i++) rd_expect("R3", enc_bus(words[i]), 1'b1, words[i], 1'b0, 1'b0);

    // R4 / R5: every single flip on several words
    for (int i = 0; i < 5; i++) begin
      for (int b = 0; b < 40; b++) begin
        logic [39:0] bus;
        bus = enc_bus(words[i]) ^ (40'd1 << b);
        rd_expect((b < 32) ? "R4" : "R5", bus, 1'b1, words[i], 1'b1, 1'b0);
      end
    end
    // R11: pulse drops on the next idle cycle
    @(negedge clk);
    check("R11", "pulse drop valid", 64'(rd_valid), 64'(0));
    check("R11", "pulse drop ce", 64'(rd_ce), 64'(0));

    // R6: every pair of flips
    for (int a = 0; a < 40; a++) begin
      for (int b = a + 1; b < 40; b++) begin
        logic [39:0] bus;
        bus = enc_bus(words[2]) ^ (40'd1 << a) ^ (40'd1 << b);
        rd_expect("R6", bus, 1'b0, '0, 1'b0, 1'b1);
      end
    end

    // R7: stuck patterns
    rd_expect("R7", 40'h00_0000_0000, 1'b0, '0, 1'b0, 1'b1);
    rd_expect("R7", 40'hFF_FFFF_FFFF, 1'b0, '0, 1'b0, 1'b1);
    for (int n = 0; n < 8; n++) begin
      logic [31:0] nm;
      nm = 32'hF << (4 * n);
      rd_expect("R7", {1'b0, 7'h00, nm}, 1'b0, '0, 1'b0, 1'b1);
      rd_expect("R7", {1'b1, 7'h7F, ~nm}, 1'b0, '0, 1'b0, 1'b1);
    end

    // R8: parity only
    mode = 2'b01;
    rd_expect("R8", enc_bus(words[2]), 1'b1, words[2], 1'b0, 1'b0);
    rd_expect("R8", enc_bus(words[2]) ^ 40'h20, 1'b1, words[2] ^ 32'h20, 1'b0, 1'b1);
    rd_expect("R8", enc_bus(words[2]) ^ (40'h7F << 32), 1'b1, words[2], 1'b0, 1'b0);

    // R9: none
    mode = 2'b00;
    rd_expect("R9", enc_bus(words[3]) ^ 40'h3, 1'b1, words[3] ^ 32'h3, 1'b0, 1'b0);
    rd_expect("R9", 40'h00_0000_0000, 1'b1, 32'h0, 1'b0, 1'b0);

    // R10: io read in correction mode
    mode = 2'b10; io_acc = 1'b1;
    rd_expect("R10", enc_bus(words[4]) ^ 40'h100, 1'b1, words[4] ^ 32'h100, 1'b0, 1'b1);
    rd_expect("R10", enc_bus(words[4]) ^ (40'h1 << 33), 1'b1, words[4], 1'b0, 1'b0);
    io_acc = 1'b0;

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule